// File: doc/BRIEF.md
# Pixel Quad Wavefront Packer

The packer sits between a rasterizer and the shader dispatch. It takes a stream of 2x2 pixel quads and groups them into 64-lane wavefronts, with 16 quads per wavefront. Each quad arrives with a draw identifier, a screen position and a 4-bit coverage mask. Each quad occupies four consecutive lanes. The packer never mixes two draws in one wavefront. A change of draw identifier therefore closes the wavefront being built. An explicit flush pin also closes it. A partial wavefront travels with its unused lanes switched off in an execution mask. Lanes whose coverage bit is clear stay enabled, because they act as helper pixels, and a separate coverage mask marks which lanes are really covered.

Both the quad input and the wavefront output are valid/ready streams. A transfer takes place on a rising clock edge where valid and ready are both high. The output holds a single wavefront register. Input ready equals "output register empty, or output ready high". The packer therefore stalls its input only while a finished wavefront cannot move on. A wavefront waiting at the output keeps every payload field unchanged until it is taken. The flush pin is a plain control input. It takes effect only in a cycle where the output register can accept a wavefront.

Top module: `quad_wave_packer`

## Requirements
- R1: After reset, out_valid is low, in_ready is high and no quads are pending, so the first quad accepted goes into lane group 0.
- R2: Quads fill lane groups in arrival order. Quad k uses lanes 4k..4k+3. Its x position sits at out_pos[32k +: 16] and its y position at out_pos[32k+16 +: 16].
- R3: When the 16th quad of one draw is accepted, the full wavefront is captured on that same edge. out_valid is high from the next cycle with out_exec all ones.
- R4: A quad whose draw identifier differs from the pending draw closes the pending wavefront, which carries the old identifier. The new quad becomes lane group 0 of the next wavefront.
- R5: out_exec has all four bits set for each occupied lane group, whatever the coverage. For unused groups, out_exec, out_cov and out_pos are zero.
- R6: out_cov bit 4k+i equals bit i of the coverage mask of quad k.
- R7: A flush with quads pending closes them into a wavefront. A quad accepted in the same cycle is not part of that wavefront and starts the next one.
- R8: A flush with no quads pending emits nothing.
- R9: in_ready is high exactly when out_valid is low or out_ready is high. While out_valid is high and out_ready is low, every output field stays stable, and a flush has no effect.
- R10: out_quads gives the number of occupied lane groups in the presented wavefront (1 to 16).
- R11: A draw of N quads, closed by a flush, produces ceil(N/16) wavefronts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Quad offered |
| in_ready | output | 1 | Quad can be taken this cycle |
| in_draw | input | DRAW_W | Draw identifier of the quad |
| in_x | input | POS_W | Quad x position |
| in_y | input | POS_W | Quad y position |
| in_cov | input | 4 | Coverage; bit i is lane i of the quad |
| flush | input | 1 | Close any pending partial wavefront |
| out_valid | output | 1 | Wavefront presented |
| out_ready | input | 1 | Consumer takes the wavefront |
| out_draw | output | DRAW_W | Draw identifier of the wavefront |
| out_pos | output | 16*2*POS_W | Per-group positions, x low and y high within each group |
| out_exec | output | 64 | Lane execution mask |
| out_cov | output | 64 | Lane coverage mask |
| out_quads | output | 5 | Occupied lane groups |

## Verification
The bench drives several patterns: one draw that fills exactly one wavefront, short draws cut by identifier changes, flushes that coincide with an accepted quad, and flushes with nothing pending. Each pattern separates one closing rule from the others. Identifier changes show whether the closed wavefront carries the old draw. Coincident flushes show whether the new quad lands before or after the cut. A long draw under pseudo-random output back-pressure checks the stall rule, output stability and the number of wavefronts per draw. Quads with zero coverage separate the execution mask from the coverage mask.

// File: rtl/qwp_pkg.sv
package qwp_pkg;
  localparam int QUAD_LANES = 4;

  typedef enum logic [1:0] {
    CL_NONE = 2'd0,
    CL_OLD  = 2'd1,
    CL_FULL = 2'd2
  } close_e;
endpackage

// File: rtl/qwp_ctrl.sv
module qwp_ctrl
  import qwp_pkg::*;
#(
  parameter int QUADS  = 16,
  parameter int DRAW_W = 8,
  parameter int CNT_W  = 5,
  parameter int IDX_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DRAW_W-1:0] in_draw,
  input  logic              flush,
  input  logic              out_free,
  output logic              accept,
  output logic [IDX_W-1:0]  wr_idx,
  output close_e            close,
  output logic [CNT_W-1:0]  held_cnt,
  output logic              use_new,
  output logic [DRAW_W-1:0] wave_draw,
  output logic [DRAW_W-1:0] pend_draw
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(QUADS - 1);

  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [DRAW_W-1:0] draw_q, draw_d;
  logic              pending, cut;

  assign accept  = in_valid & out_free;
  assign pending = (cnt_q != '0);
  // a cut closes the quads already held, before any quad arriving now
  assign cut     = pending & (flush | (accept & (in_draw != draw_q)));

  always_comb begin
    cnt_d  = cnt_q;
    draw_d = draw_q;
    close  = CL_NONE;
    wr_idx = cnt_q[IDX_W-1:0];
    if (out_free) begin
      if (cut) begin
        close  = CL_OLD;
        wr_idx = '0;
        if (accept) begin
          cnt_d  = CNT_W'(1);
          draw_d = in_draw;
        end else begin
          cnt_d = '0;
        end
      end else if (accept) begin
        draw_d = in_draw;
        if (cnt_q == LAST) begin
          close = CL_FULL;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + CNT_W'(1);
        end
      end
    end
  end

  assign use_new   = (close == CL_FULL);
  assign held_cnt  = cnt_q;
  assign wave_draw = (close == CL_OLD) ? draw_q : in_draw;
  assign pend_draw = draw_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      draw_q <= '0;
    end else begin
      cnt_q  <= cnt_d;
      draw_q <= draw_d;
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST); // R3

  AST_FLUSH_EMPTY_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '0 && !accept) |-> close == CL_NONE); // R8
endmodule

// File: rtl/qwp_slot_array.sv
module qwp_slot_array #(
  parameter int QUADS = 16,
  parameter int POS_W = 16,
  parameter int CNT_W = 5,
  parameter int IDX_W = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     we,
  input  logic [IDX_W-1:0]         wr_idx,
  input  logic [POS_W-1:0]         in_x,
  input  logic [POS_W-1:0]         in_y,
  input  logic [3:0]               in_cov,
  input  logic [CNT_W-1:0]         held_cnt,
  input  logic                     use_new,
  output logic [QUADS*2*POS_W-1:0] wave_pos,
  output logic [QUADS*4-1:0]       wave_exec,
  output logic [QUADS*4-1:0]       wave_cov,
  output logic [CNT_W-1:0]         wave_quads
);
  localparam int GRP_W = 2 * POS_W;

  for (genvar q = 0; q < QUADS; q++) begin : g_slot
    logic [POS_W-1:0] sx, sy;
    logic [3:0]       sc;
    logic             from_old, from_new;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sx <= '0;
        sy <= '0;
        sc <= '0;
      end else if (we && wr_idx == IDX_W'(q)) begin
        sx <= in_x;
        sy <= in_y;
        sc <= in_cov;
      end
    end

    assign from_old = (CNT_W'(q) < held_cnt);
    assign from_new = use_new && (CNT_W'(q) == held_cnt);

    always_comb begin
      wave_pos[q*GRP_W +: GRP_W] = '0;
      wave_exec[q*4 +: 4]        = '0;
      wave_cov[q*4 +: 4]         = '0;
      if (from_old) begin
        wave_pos[q*GRP_W +: GRP_W] = {sy, sx};
        wave_exec[q*4 +: 4]        = 4'hF;
        wave_cov[q*4 +: 4]         = sc;
      end else if (from_new) begin
        wave_pos[q*GRP_W +: GRP_W] = {in_y, in_x};
        wave_exec[q*4 +: 4]        = 4'hF;
        wave_cov[q*4 +: 4]         = in_cov;
      end
    end
  end

  assign wave_quads = held_cnt + CNT_W'(use_new);
endmodule

// File: rtl/qwp_out_stage.sv
module qwp_out_stage #(
  parameter int DRAW_W = 8,
  parameter int POS_BITS = 512,
  parameter int LANES = 64,
  parameter int CNT_W = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic [DRAW_W-1:0]   d_draw,
  input  logic [POS_BITS-1:0] d_pos,
  input  logic [LANES-1:0]    d_exec,
  input  logic [LANES-1:0]    d_cov,
  input  logic [CNT_W-1:0]    d_quads,
  input  logic                out_ready,
  output logic                out_valid,
  output logic                out_free,
  output logic [DRAW_W-1:0]   out_draw,
  output logic [POS_BITS-1:0] out_pos,
  output logic [LANES-1:0]    out_exec,
  output logic [LANES-1:0]    out_cov,
  output logic [CNT_W-1:0]    out_quads
);
  assign out_free = ~out_valid | out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_draw  <= '0;
      out_pos   <= '0;
      out_exec  <= '0;
      out_cov   <= '0;
      out_quads <= '0;
    end else if (load) begin
      out_valid <= 1'b1;
      out_draw  <= d_draw;
      out_pos   <= d_pos;
      out_exec  <= d_exec;
      out_cov   <= d_cov;
      out_quads <= d_quads;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_draw) && $stable(out_exec)
      && $stable(out_cov) && $stable(out_pos) && $stable(out_quads))); // R9

  AST_NONEMPTY_WAVE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_exec != '0 && out_quads != '0)); // R8

  AST_COV_INSIDE_EXEC: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((out_cov & ~out_exec) == '0)); // R5
endmodule

// File: rtl/quad_wave_packer.sv
module quad_wave_packer
  import qwp_pkg::*;
#(
  parameter int DRAW_W     = 8,
  parameter int POS_W      = 16,
  parameter int WAVE_LANES = 64
) (
  input  logic                                          clk,
  input  logic                                          rst_n,
  input  logic                                          in_valid,
  output logic                                          in_ready,
  input  logic [DRAW_W-1:0]                             in_draw,
  input  logic [POS_W-1:0]                              in_x,
  input  logic [POS_W-1:0]                              in_y,
  input  logic [3:0]                                    in_cov,
  input  logic                                          flush,
  output logic                                          out_valid,
  input  logic                                          out_ready,
  output logic [DRAW_W-1:0]                             out_draw,
  output logic [(WAVE_LANES/QUAD_LANES)*2*POS_W-1:0]    out_pos,
  output logic [WAVE_LANES-1:0]                         out_exec,
  output logic [WAVE_LANES-1:0]                         out_cov,
  output logic [$clog2(WAVE_LANES/QUAD_LANES+1)-1:0]    out_quads
);
  localparam int QUADS    = WAVE_LANES / QUAD_LANES;
  localparam int CNT_W    = $clog2(QUADS + 1);
  localparam int IDX_W    = $clog2(QUADS);
  localparam int POS_BITS = QUADS * 2 * POS_W;

  logic              out_free, accept, use_new;
  close_e            close;
  logic [IDX_W-1:0]  wr_idx;
  logic [CNT_W-1:0]  held_cnt, wave_quads;
  logic [DRAW_W-1:0] wave_draw, pend_draw;
  logic [POS_BITS-1:0]   wave_pos;
  logic [WAVE_LANES-1:0] wave_exec, wave_cov;

  assign in_ready = out_free;

  qwp_ctrl #(.QUADS(QUADS), .DRAW_W(DRAW_W), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_draw(in_draw), .flush(flush),
    .out_free(out_free), .accept(accept), .wr_idx(wr_idx), .close(close),
    .held_cnt(held_cnt), .use_new(use_new), .wave_draw(wave_draw), .pend_draw(pend_draw)
  );

  qwp_slot_array #(.QUADS(QUADS), .POS_W(POS_W), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_slots (
    .clk(clk), .rst_n(rst_n), .we(accept), .wr_idx(wr_idx), .in_x(in_x), .in_y(in_y),
    .in_cov(in_cov), .held_cnt(held_cnt), .use_new(use_new), .wave_pos(wave_pos),
    .wave_exec(wave_exec), .wave_cov(wave_cov), .wave_quads(wave_quads)
  );

  qwp_out_stage #(.DRAW_W(DRAW_W), .POS_BITS(POS_BITS), .LANES(WAVE_LANES), .CNT_W(CNT_W)) u_out (
    .clk(clk), .rst_n(rst_n), .load(close != CL_NONE), .d_draw(wave_draw), .d_pos(wave_pos),
    .d_exec(wave_exec), .d_cov(wave_cov), .d_quads(wave_quads), .out_ready(out_ready),
    .out_valid(out_valid), .out_free(out_free), .out_draw(out_draw), .out_pos(out_pos),
    .out_exec(out_exec), .out_cov(out_cov), .out_quads(out_quads)
  );

  AST_FULL_SAME_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !flush && held_cnt == CNT_W'(QUADS - 1) && in_draw == pend_draw)
      |=> (out_valid && out_exec == '1)); // R3

  AST_DRAW_CHANGE_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && held_cnt != '0 && in_draw != pend_draw)
      |=> (out_valid && out_draw == $past(pend_draw) && out_quads == $past(held_cnt))); // R4
endmodule

// File: tb/tb_quad_wave_packer.sv
`timescale 1ns/100ps
module tb_quad_wave_packer;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_ready, flush = 1'b0, out_valid, out_ready = 1'b0;
  logic [7:0] in_draw = '0, out_draw;
  logic [15:0] in_x = '0, in_y = '0;
  logic [3:0] in_cov = '0;
  logic [511:0] out_pos;
  logic [63:0] out_exec, out_cov;
  logic [4:0] out_quads;

  always #2 clk = ~clk;

  quad_wave_packer dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_draw(in_draw),
    .in_x(in_x), .in_y(in_y), .in_cov(in_cov), .flush(flush), .out_valid(out_valid),
    .out_ready(out_ready), .out_draw(out_draw), .out_pos(out_pos), .out_exec(out_exec),
    .out_cov(out_cov), .out_quads(out_quads)
  );

  int checks = 0, errors = 0;
  bit done = 0;

  // reference model state
  int m_cnt = 0;
  int m_draw = 0;
  int qx[16], qy[16], qc[16];
  bit mo_valid = 0;
  logic [7:0]   mo_draw = '0;
  logic [511:0] mo_pos = '0;
  logic [63:0]  mo_exec = '0, mo_cov = '0;
  int           mo_quads = 0;
  int waves[256];

  // last sampled outputs
  bit s_valid;
  logic [63:0] s_exec, s_cov;
  logic [7:0] s_draw;
  logic [511:0] s_pos;
  int s_quads;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [511:0] act, input logic [511:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic build();
    mo_valid = 1;
    mo_draw  = 8'(m_draw);
    mo_pos   = '0;
    mo_exec  = '0;
    mo_cov   = '0;
    mo_quads = m_cnt;
    for (int k = 0; k < m_cnt; k++) begin
      mo_pos[k*32 +: 16]    = 16'(qx[k]);
      mo_pos[k*32+16 +: 16] = 16'(qy[k]);
      for (int i = 0; i < 4; i++) begin
        mo_exec[4*k+i] = 1'b1;
        mo_cov[4*k+i]  = qc[k][i];
      end
    end
  endtask

  task automatic cyc(input bit v, input int d, input int x, input int y, input int cv,
                     input bit fl, input bit rdy, input string tag);
    bit free, acc, built;
    @(negedge clk);
    in_valid = v; in_draw = 8'(d); in_x = 16'(x); in_y = 16'(y);
    in_cov = 4'(cv); flush = fl; out_ready = rdy;
    #1;
    free = !mo_valid || rdy;
    s_valid = out_valid; s_exec = out_exec; s_cov = out_cov; s_draw = out_draw;
    s_pos = out_pos; s_quads = int'(out_quads);
    chk(in_ready == free, tag, "in_ready", 512'(in_ready), 512'(free));
    chk(out_valid == mo_valid, tag, "out_valid", 512'(out_valid), 512'(mo_valid));
    if (mo_valid && out_valid) begin
      chk(out_draw == mo_draw, tag, "out_draw", 512'(out_draw), 512'(mo_draw));
      chk(out_exec == mo_exec, tag, "out_exec", 512'(out_exec), 512'(mo_exec));
      chk(out_cov == mo_cov, tag, "out_cov", 512'(out_cov), 512'(mo_cov));
      chk(out_pos == mo_pos, tag, "out_pos", out_pos, mo_pos);
      chk(int'(out_quads) == mo_quads, tag, "out_quads", 512'(out_quads), 512'(mo_quads));
      if (rdy) waves[out_draw]++;
    end
    acc = v && free;
    built = 0;
    if (free) begin
      if (m_cnt > 0 && (fl || (acc && d != m_draw))) begin
        build(); built = 1; m_cnt = 0;
      end
      if (acc) begin
        qx[m_cnt] = x; qy[m_cnt] = y; qc[m_cnt] = cv; m_draw = d; m_cnt++;
        if (m_cnt == 16) begin build(); built = 1; m_cnt = 0; end
      end
      if (!built) mo_valid = 0;
    end
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0, 0, 1, tag);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    bit [15:0] lf;
    lf = 16'hACE1;
    for (int i = 0; i < 256; i++) waves[i] = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1: reset state
    cyc(0, 0, 0, 0, 0, 0, 1, "R1");
    chk(s_valid == 0, "R1", "out_valid after reset", 512'(s_valid), 512'(0));

    // R2 R3 R6: one exact full wavefront, varied coverage
    for (int k = 0; k < 16; k++) cyc(1, 5, 100 + k, 200 + 3*k, (k * 7) & 15, 0, 1, "R2");
    cyc(0, 0, 0, 0, 0, 0, 1, "R3");
    chk(s_valid == 1 && s_exec == '1, "R3", "full wave exec next cycle", 512'(s_exec), 512'({64{1'b1}}));
    chk(s_pos[15*32 +: 16] == 16'd115, "R2", "group 15 x position", 512'(s_pos[15*32 +: 16]), 512'(115));
    chk(s_cov[4*3 +: 4] == 4'(21 & 15), "R6", "group 3 coverage", 512'(s_cov[12 +: 4]), 512'(21 & 15));
    idle(2, "R3");

    // R4 R5: draw changes cut partial wavefronts
    for (int k = 0; k < 5; k++) cyc(1, 1, k, k + 1, 4'hF, 0, 1, "R4");
    cyc(1, 2, 50, 51, 4'h1, 0, 1, "R4");
    cyc(1, 2, 52, 53, 4'h0, 0, 1, "R4");
    chk(s_valid && s_draw == 8'd1 && s_quads == 5, "R4", "closed wave draw", 512'(s_draw), 512'(1));
    chk(s_exec == 64'h0000_0000_000F_FFFF, "R5", "partial exec mask", 512'(s_exec), 512'(64'hF_FFFF));
    cyc(1, 2, 54, 55, 4'h8, 0, 1, "R5");
    cyc(0, 0, 0, 0, 0, 1, 1, "R7");
    cyc(0, 0, 0, 0, 0, 0, 1, "R10");
    chk(s_valid && s_quads == 3 && s_cov[11:0] == 12'h801, "R10", "three-quad wave", 512'(s_quads), 512'(3));
    chk(s_pos[511:96] == '0, "R5", "unused positions zero", s_pos[511:96], 512'(0));

    // R7: flush together with a quad
    for (int k = 0; k < 3; k++) cyc(1, 3, k, k, 4'h3, 0, 1, "R7");
    cyc(1, 3, 9, 9, 4'h5, 1, 1, "R7");
    cyc(0, 0, 0, 0, 0, 0, 1, "R7");
    chk(s_valid && s_quads == 3, "R7", "flush excludes same-cycle quad", 512'(s_quads), 512'(3));
    cyc(0, 0, 0, 0, 0, 1, 1, "R7");
    cyc(0, 0, 0, 0, 0, 0, 1, "R7");
    chk(s_valid && s_quads == 1 && s_pos[15:0] == 16'd9, "R7", "held quad in next wave", 512'(s_pos[15:0]), 512'(9));

    // R8: flush with nothing pending
    idle(1, "R8");
    cyc(0, 0, 0, 0, 0, 1, 1, "R8");
    cyc(0, 0, 0, 0, 0, 1, 1, "R8");
    chk(s_valid == 0, "R8", "empty flush emits nothing", 512'(s_valid), 512'(0));
    idle(1, "R8");

    // R9: back-pressure, stable output, flush ignored while blocked
    for (int k = 0; k < 16; k++) cyc(1, 4, k, 0, 4'hF, 0, 0, "R9");
    for (int k = 0; k < 2; k++) cyc(1, 4, 60 + k, 0, 4'hA, 0, 0, "R9");
    cyc(1, 4, 70, 0, 4'hA, 0, 0, "R9");
    cyc(0, 0, 0, 0, 0, 1, 0, "R9");
    chk(s_valid && s_quads == 16, "R9", "held wave while stalled", 512'(s_quads), 512'(16));
    cyc(1, 4, 71, 0, 4'h2, 0, 1, "R9");
    cyc(1, 4, 72, 0, 4'h2, 1, 1, "R9");
    cyc(0, 0, 0, 0, 0, 0, 1, "R9");
    chk(s_valid && s_quads == 1, "R9", "wave after release", 512'(s_quads), 512'(1));
    cyc(0, 0, 0, 0, 0, 1, 1, "R9");
    idle(2, "R9");

    // R11: long draw under random back-pressure
    waves[9] = 0;
    for (int k = 0; k < 40; k++) begin
      bit sent;
      sent = 0;
      while (!sent) begin
        bit rdy;
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        rdy = lf[0] | lf[3];
        sent = !mo_valid || rdy;
        cyc(1, 9, k * 3, k * 5, int'(lf[7:4]), 0, rdy, "R11");
      end
    end
    cyc(0, 0, 0, 0, 0, 1, 1, "R11");
    idle(4, "R11");
    chk(waves[9] == 3, "R11", "wavefronts for 40 quads", 512'(waves[9]), 512'(3));

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule